// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block puts an on-chip word array behind a command interpreter, so that a bus master sees a parallel NOR flash with the common Intel-style command set. The bus is a simple synchronous one. It has a word address, 16-bit write data, 16-bit read data, a write strobe and a read strobe. The low byte of a write carries the command code. Multi-cycle sequences arm single-word program, sector erase and buffered block write. A small command state machine chooses what a read returns: array words, the status register, identification codes or a byte of the query table.

The array is held in registers inside the block and comes out of reset erased, with every bit set. A sector is a power-of-two group of words. Operations complete in the same cycle as their final bus write, so the ready bit (status bit 7) is set at once. Protection, timing and suspend are not modelled. The lock commands are accepted and have no effect.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset every array word reads 16'hFFFF, the status register is 8'h80 and the block is in read-array mode.
- R2: A write whose low byte is 8'hFF returns the block to read-array mode. This holds in idle, command-armed and confirm phases, but not while buffered data words arrive. A first-cycle code the block does not know also returns it to read-array mode and leaves the array unchanged.
- R3: Code 8'h10 or 8'h40 arms a program. The next write stores its data at its address, sets status bit 7 and returns the block to read-array mode.
- R4: Code 8'h20 followed by 8'hD0 sets every word of the sector that holds the second write's address to 16'hFFFF. The sector is found by clearing the low SECT_AW address bits. The sequence sets status bit 7, and reads then return the status.
- R5: After 8'h20, a second value other than 8'hD0 or 8'hFF abandons the sequence, returns to read-array mode and leaves the array unchanged.
- R6: Code 8'h50 clears the whole status register and 8'h70 selects status reads. While the mode is erase, clear-status, lock, status or buffered write, a read returns {8'h00, status}.
- R7: Code 8'h90 selects identification reads. Word address 0 returns MFR_ID, word address 1 returns DEV_ID and any other address returns 0.
- R8: Code 8'h98 selects query reads. These return {8'h00, byte} indexed by address bits 7:0, with 8'h51/8'h52/8'h59 at 8'h10..8'h12, ADDR_W+1 at 8'h27, $clog2(BUF_WORDS)+1 at 8'h2A and sector count minus one at 8'h2D. Any index at or above QRY_LEN returns 0.
- R9: Code 8'hE8 sets status bit 7 and arms a buffered write. The next write's low $clog2(BUF_WORDS) bits give N. The following N+1 writes store their data at their addresses verbatim, 8'hFF low bytes included.
- R10: After the buffered data, a write of 8'hD0 returns the block to read-array mode. Any other value also returns it to read-array mode, and the data already stored is kept.
- R11: Code 8'h60 followed by 8'hD0 or 8'h01 is accepted, leaves the array unchanged and leaves status reads selected. Any other second value returns the block to read-array mode.
- R12: Read data is registered. It appears the cycle after a read strobe and holds while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; the low byte is the command code |
| we | input | 1 | Write strobe, one cycle per bus write |
| re | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |

## Verification
The bench builds the block with 256 words in 16-word sectors and an 8-word buffer. At that size one erase spans two sector boundaries, so the first and last words of a sector can be checked against the next sector's first word. A buffer count of 9 exceeds the buffer and folds to two data words, which exercises the count truncation. The query bytes derived from these parameters (9, 4 and 15) are checked at their indices, along with an index past the 64-byte table.

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int          ADDR_W    = 8,
  parameter int          SECT_AW   = 4,
  parameter int          BUF_WORDS = 8,
  parameter int          QRY_LEN   = 64,
  parameter logic [15:0] MFR_ID    = 16'h0089,
  parameter logic [15:0] DEV_ID    = 16'h0018
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              we,
  input  logic              re,
  output logic [15:0]       rdata
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int NSECT = 1 << (ADDR_W - SECT_AW);
  localparam int CNT_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  localparam logic [7:0] M_ARRAY = 8'h00, K_PROG_A = 8'h10, K_PROG_B = 8'h40,
                         K_ERASE = 8'h20, K_CLR = 8'h50, K_LOCK = 8'h60,
                         K_STAT = 8'h70, K_ID = 8'h90, K_QRY = 8'h98,
                         K_BUF = 8'hE8, K_OK = 8'hD0, K_LK = 8'h01, K_EXIT = 8'hFF;

  logic [15:0]      mem [WORDS];
  logic [7:0]       mode;
  logic [1:0]       phase;
  logic [CNT_W-1:0] left;
  logic [7:0]       status;

  wire [7:0] cb       = wdata[7:0];
  wire       prog_arm = (mode == K_PROG_A) || (mode == K_PROG_B);
  wire       erase_go = we && phase == 2'd1 && mode == K_ERASE && cb == K_OK;
  wire       store_go = we && ((phase == 2'd1 && prog_arm) || phase == 2'd2);
  wire [ADDR_W-SECT_AW-1:0] sect = addr[ADDR_W-1:SECT_AW];

  function automatic logic [7:0] qry(input logic [7:0] i);
    if (int'(i) >= QRY_LEN) return 8'h00;
    case (i)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      8'h13:   return 8'h01;
      8'h15:   return 8'h31;
      8'h27:   return 8'(ADDR_W + 1);
      8'h2A:   return 8'(CNT_W + 1);
      8'h2C:   return 8'h01;
      8'h2D:   return 8'(NSECT - 1);
      8'h2E:   return 8'((NSECT - 1) >> 8);
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        logic [ADDR_W-1:0] ia;
        ia = ADDR_W'(i);
        if (erase_go && ia[ADDR_W-1:SECT_AW] == sect) mem[i] <= '1;
      end
      if (store_go) mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_ARRAY;
      phase  <= 2'd0;
      left   <= '0;
      status <= 8'h80;
    end else if (we) begin
      case (phase)
        2'd0: begin
          case (cb)
            K_PROG_A, K_PROG_B, K_ERASE, K_LOCK: begin
              mode <= cb; phase <= 2'd1;
            end
            K_BUF:        begin mode <= cb; phase <= 2'd1; status[7] <= 1'b1; end
            K_CLR:        begin mode <= cb; status <= 8'h00; end
            K_STAT, K_ID, K_QRY: mode <= cb;
            default:      mode <= M_ARRAY;
          endcase
        end
        2'd1: begin
          phase <= 2'd0;
          if (prog_arm) begin
            status[7] <= 1'b1;
            mode      <= M_ARRAY;
          end else if (mode == K_ERASE) begin
            if (cb == K_OK) status[7] <= 1'b1;
            else            mode <= M_ARRAY;
          end else if (mode == K_BUF) begin
            if (cb == K_EXIT) mode <= M_ARRAY;
            else begin
              left  <= wdata[CNT_W-1:0];
              phase <= 2'd2;
            end
          end else if (mode == K_LOCK) begin
            if (cb != K_OK && cb != K_LK) mode <= M_ARRAY;
          end else begin
            mode <= M_ARRAY;
          end
        end
        2'd2: begin
          if (left == '0) phase <= 2'd3;
          else            left  <= left - 1'b1;
        end
        default: begin
          phase <= 2'd0;
          mode  <= M_ARRAY;
          if (cb == K_OK) status[7] <= 1'b1;
        end
      endcase
    end
  end

  logic [15:0] rmux;
  always_comb begin
    case (mode)
      M_ARRAY:                             rmux = mem[addr];
      K_ERASE, K_CLR, K_LOCK, K_STAT, K_BUF: rmux = {8'h00, status};
      K_ID:    rmux = (addr == '0) ? MFR_ID : (addr == ADDR_W'(1)) ? DEV_ID : 16'h0000;
      K_QRY:   rmux = {8'h00, qry(addr[7:0])};
      default: rmux = mem[addr];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '1;
    else if (re) rdata <= rmux;
  end

  a_r2_exit_to_array: assert property (@(posedge clk) disable iff (!rst_n)
    (we && cb == K_EXIT && phase != 2'd2) |=> (mode == M_ARRAY && phase == 2'd0));
  a_r3_prog_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (we && phase == 2'd1 && prog_arm) |=> (mem[$past(addr)] == $past(wdata) && status[7]));
  a_r4_erase_ready: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (status[7] && mode == K_ERASE && mem[$past(addr)] == 16'hFFFF));
  a_r6_clear_status: assert property (@(posedge clk) disable iff (!rst_n)
    (we && phase == 2'd0 && cb == K_CLR) |=> (status == 8'h00));
  a_r9_buf_phase_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= 2'd2) |-> (mode == K_BUF));
  a_r9_buf_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (we && phase == 2'd2 && left != '0) |=> (phase == 2'd2));
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));
endmodule

// File: tb/nor_cmd_flash_tb_top.sv
module nor_cmd_flash_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 8;

  logic          clk = 0, rst_n = 0, we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          rd_pend = 0;

  int    checks = 0, fails = 0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  nor_cmd_flash #(.ADDR_W(AW), .SECT_AW(4), .BUF_WORDS(8), .QRY_LEN(64),
                  .MFR_ID(16'h0089), .DEV_ID(16'h0018)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .we(we), .re(re), .rdata(rdata));

  always @(posedge clk) rd_pend <= re;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      int e; string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== 16'(e)) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, rdata, 16'(e));
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
    @(negedge clk); re = 1; addr = a;
    exp_q.push_back(int'(e)); tag_q.push_back(t);
    @(negedge clk); re = 0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, 16'hFFFF, "R1 array erased");
    rd(8'hFF, 16'hFFFF, "R1 last word erased");
    wr(0, 16'h0070);
    rd(0, 16'h0080, "R1 status after reset");
    // R12 hold: no strobe, then read again same value
    repeat (2) @(negedge clk);
    checks++;
    if (rdata !== 16'h0080) begin fails++; $display("FAIL R12 hold: got %h expected 0080", rdata); end
    // R3 program
    wr(0, 16'h0040); wr(8'h05, 16'h1234);
    rd(8'h05, 16'h1234, "R3 program 40");
    wr(0, 16'h0010); wr(8'h06, 16'hBEEF);
    rd(8'h06, 16'hBEEF, "R3 program 10");
    // R6 clear status, then program sets ready
    wr(0, 16'h0050);
    rd(0, 16'h0000, "R6 cleared status");
    wr(0, 16'h0040); wr(8'h07, 16'h55AA);
    wr(0, 16'h0070);
    rd(0, 16'h0080, "R3 ready after program");
    // R4 erase sector 2
    wr(0, 16'h0040); wr(8'h20, 16'h1111);
    wr(0, 16'h0040); wr(8'h2F, 16'h2222);
    wr(0, 16'h0040); wr(8'h30, 16'h3333);
    wr(0, 16'h0050);
    wr(0, 16'h0020); wr(8'h27, 16'h00D0);
    rd(8'h30, 16'h0080, "R4 status mode after erase");
    wr(0, 16'h00FF);
    rd(8'h20, 16'hFFFF, "R4 sector first word");
    rd(8'h2F, 16'hFFFF, "R4 sector last word");
    rd(8'h30, 16'h3333, "R4 next sector untouched");
    // R5 abandoned erase
    wr(0, 16'h0020); wr(8'h30, 16'h0012);
    rd(8'h30, 16'h3333, "R5 abandoned erase");
    // R2 exit from armed erase
    wr(0, 16'h0020); wr(8'h30, 16'h00FF);
    rd(8'h30, 16'h3333, "R2 exit from erase arm");
    // R7 identification
    wr(0, 16'h0090);
    rd(0, 16'h0089, "R7 manufacturer");
    rd(1, 16'h0018, "R7 device");
    rd(2, 16'h0000, "R7 other address");
    // R8 query
    wr(0, 16'h0098);
    rd(8'h10, 16'h0051, "R8 Q");
    rd(8'h12, 16'h0059, "R8 Y");
    rd(8'h27, 16'h0009, "R8 size");
    rd(8'h2A, 16'h0004, "R8 buffer");
    rd(8'h2D, 16'h000F, "R8 sectors");
    rd(8'h50, 16'h0000, "R8 past table");
    wr(0, 16'h00FF);
    rd(8'h05, 16'h1234, "R2 exit from query");
    // R9 buffered write, 4 words incl an FF low byte
    wr(0, 16'h0050);
    wr(0, 16'h00E8);
    rd(0, 16'h0080, "R9 status on buffer start");
    wr(0, 16'h0003);
    wr(8'h40, 16'hA001); wr(8'h41, 16'h00FF); wr(8'h42, 16'hA003); wr(8'h43, 16'hA004);
    wr(0, 16'h00D0);
    rd(8'h40, 16'hA001, "R9 buffer word 0");
    rd(8'h41, 16'h00FF, "R9 buffer FF data stored");
    rd(8'h43, 16'hA004, "R10 confirm to array");
    // R9 count truncated: 9 -> 1 -> two words
    wr(0, 16'h00E8); wr(0, 16'h0009);
    wr(8'h60, 16'hB001); wr(8'h61, 16'hB002);
    wr(8'h62, 16'h00D0);
    rd(8'h61, 16'hB002, "R9 truncated count word 1");
    rd(8'h62, 16'hFFFF, "R9 confirm not stored");
    // R10 bad confirm
    wr(0, 16'h00E8); wr(0, 16'h0000); wr(8'h50, 16'h7777); wr(0, 16'h0011);
    rd(8'h50, 16'h7777, "R10 bad confirm keeps data");
    // R11 lock sequences
    wr(0, 16'h0060); wr(8'h05, 16'h00D0);
    rd(8'h05, 16'h0080, "R11 unlock status mode");
    wr(0, 16'h0060); wr(8'h05, 16'h0001);
    rd(8'h05, 16'h0080, "R11 lock status mode");
    wr(0, 16'h0060); wr(8'h05, 16'h0033);
    rd(8'h05, 16'h1234, "R11 bad lock to array");
    // R2 unknown command
    wr(8'h05, 16'h0077);
    rd(8'h05, 16'h1234, "R2 unknown command");
    wr(0, 16'h0070); wr(8'h05, 16'h00AB);
    rd(8'h05, 16'h1234, "R2 unknown from status mode");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule